// File: doc/BRIEF.md
# Increment-and-Skip Execution Unit

This unit carries out the two increment-and-conditionally-skip instructions of a small 8-bit Harvard-style core. Each instruction cycle is four quarter phases long. In the decode phase the unit takes a 16-bit instruction word from fetch, recognises one of the two opcodes and forms a 12-bit data address. In the read phase it fetches the addressed byte. In the compute phase it adds one. In the write phase it stores the result either in the working register or back in the data location.

One opcode skips when the 8-bit result is zero and the other skips when it is non-zero. A skip throws away the instruction that fetch has already brought in. The unit signals this with a squash pulse in the first quarter of every discarded cycle: one cycle in the usual case, and two cycles when fetch reports that the discarded instruction is two words long. Instructions presented during a squashed cycle are ignored.

When the extended instruction set is on, some access-bank operands use indexed literal offset addressing. For those operands the unit raises a mode flag and leaves the access to a neighbouring block.

Top module: `incskip_unit`

## Requirements
- R1: Bits [15:10] select the operation: 001111 is increment-skip-if-zero and 010010 is increment-skip-if-non-zero. Any other word presented with instr_valid produces no file_rd, no file_wr, no w_wr and no squash.
- R2: Bit 8 is the bank bit and bits [7:0] are the file field f. With the bank bit at 1, file_addr = {bank_sel, f}. With it at 0, an f below 0x60 gives {4'h0, f} and an f of 0x60 or above gives {4'hF, f}.
- R3: qphase is 0 in the first cycle after reset and then counts 0,1,2,3 and wraps. file_rd is only high in phase 1, and file_wr or w_wr only in phase 3.
- R4: The result is rd_data + 1 modulo 256, so 0xFF wraps to 0x00. Bit 9 (d) at 1 raises file_wr with file_wdata = result. With d at 0, w_wr is raised with w_wdata = result instead.
- R5: When the skip condition holds, squash is high during phase 0 of the next instruction cycle. With next_two_word sampled high it is also high during phase 0 of the cycle after that. squash stays low when no skip is taken.
- R6: An instruction presented with instr_valid during a squashed phase 0 is ignored: it causes no file_rd, file_wr or w_wr in that cycle.
- R7: With ext_set_en at 1, the bank bit at 0 and f at most 0x5F, idx_mode is high in phases 1 to 3. In that case there is no file_rd, file_wr, w_wr or squash.
- R8: Reset returns qphase to 0, clears every strobe and drops any pending squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one quarter phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_word | input | 16 | Instruction word, sampled in phase 0 |
| instr_valid | input | 1 | instr_word holds an instruction to execute (phase 0) |
| next_two_word | input | 1 | The instruction behind this one is two words long (phase 0) |
| bank_sel | input | 4 | Bank select register value (phase 0) |
| ext_set_en | input | 1 | Extended instruction set enabled (phase 0) |
| rd_data | input | 8 | Data memory read byte, sampled at the end of phase 1 |
| qphase | output | 2 | Current quarter phase, 0 to 3 |
| file_addr | output | 12 | Data memory address |
| file_rd | output | 1 | Data memory read strobe |
| file_wr | output | 1 | Data memory write strobe |
| file_wdata | output | 8 | Data memory write byte |
| w_wr | output | 1 | Working register write strobe |
| w_wdata | output | 8 | Working register write byte |
| idx_mode | output | 1 | Indexed literal offset operand in progress |
| squash | output | 1 | Current cycle's fetched word is discarded |

## Verification
A squashed phase 0 is also the phase in which fetch offers the next word. The discard and the acceptance of a new instruction therefore compete in the same cycle. The bench provokes this by driving a valid, recognised instruction during every squashed phase 0, including both phases of a two-word discard. It then judges the result by checking that no read appears in the following phase 1, that no write appears in phase 3, and that squash falls exactly when the discard count is used up.

// File: rtl/incskip_pkg.sv
package incskip_pkg;
    localparam int unsigned OPC_W = 6;
    localparam logic [OPC_W-1:0] OPC_INC_SKZ  = 6'b001111;
    localparam logic [OPC_W-1:0] OPC_INC_SKNZ = 6'b010010;

    typedef enum logic [1:0] {
        PH_DEC = 2'd0,
        PH_RD  = 2'd1,
        PH_EXE = 2'd2,
        PH_WB  = 2'd3
    } qphase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SKZ  = 2'd1,
        OP_SKNZ = 2'd2
    } op_e;
endpackage

// File: rtl/incskip_decode.sv
module incskip_decode
    import incskip_pkg::*;
#(
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned DATA_W  = 8
) (
    input  logic [INSTR_W-1:0] word,
    output op_e                op,
    output logic               to_file,
    output logic               use_bank,
    output logic [DATA_W-1:0]  fsel
);
    localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
    localparam int unsigned D_BIT   = DATA_W + 1;
    localparam int unsigned A_BIT   = DATA_W;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc      = word[INSTR_W-1:OPC_LSB];
        to_file  = word[D_BIT];
        use_bank = word[A_BIT];
        fsel     = word[DATA_W-1:0];
        if (opc == OPC_INC_SKZ) begin
            op = OP_SKZ;
        end else if (opc == OPC_INC_SKNZ) begin
            op = OP_SKNZ;
        end else begin
            op = OP_NONE;
        end
    end
endmodule

// File: rtl/incskip_addr.sv
module incskip_addr #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BANK_W    = 4,
    parameter int unsigned ACC_SPLIT = 96
) (
    input  logic [DATA_W-1:0]        fsel,
    input  logic                     use_bank,
    input  logic [BANK_W-1:0]        bank_sel,
    input  logic                     ext_en,
    output logic [BANK_W+DATA_W-1:0] addr,
    output logic                     idx
);
    localparam logic [DATA_W-1:0] SPLIT = DATA_W'(ACC_SPLIT);

    logic low_half;

    always_comb begin
        low_half = (fsel < SPLIT);
        idx      = ext_en && !use_bank && low_half;
        if (use_bank) begin
            addr = {bank_sel, fsel};
        end else if (low_half) begin
            addr = {{BANK_W{1'b0}}, fsel};
        end else begin
            addr = {{BANK_W{1'b1}}, fsel};
        end
    end
endmodule

// File: rtl/incskip_unit.sv
module incskip_unit
    import incskip_pkg::*;
#(
    parameter int unsigned INSTR_W   = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BANK_W    = 4,
    parameter int unsigned ACC_SPLIT = 96,
    parameter int unsigned FLUSH_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [INSTR_W-1:0]       instr_word,
    input  logic                     instr_valid,
    input  logic                     next_two_word,
    input  logic [BANK_W-1:0]        bank_sel,
    input  logic                     ext_set_en,
    input  logic [DATA_W-1:0]        rd_data,
    output logic [1:0]               qphase,
    output logic [BANK_W+DATA_W-1:0] file_addr,
    output logic                     file_rd,
    output logic                     file_wr,
    output logic [DATA_W-1:0]        file_wdata,
    output logic                     w_wr,
    output logic [DATA_W-1:0]        w_wdata,
    output logic                     idx_mode,
    output logic                     squash
);
    localparam int unsigned ADDR_W = BANK_W + DATA_W;
    localparam logic [FLUSH_W-1:0] FLUSH_ONE = FLUSH_W'(1);
    localparam logic [FLUSH_W-1:0] FLUSH_TWO = FLUSH_W'(2);

    typedef struct packed {
        qphase_e             ph;
        logic                act;
        op_e                 op;
        logic                to_file;
        logic [ADDR_W-1:0]   addr;
        logic                idx;
        logic                two;
        logic [DATA_W-1:0]   opnd;
        logic [DATA_W-1:0]   res;
        logic                skip;
        logic [FLUSH_W-1:0]  pend;
    } state_t;

    state_t s_q, s_d;

    op_e               dec_op;
    logic              dec_to_file;
    logic              dec_use_bank;
    logic [DATA_W-1:0] dec_fsel;
    logic [ADDR_W-1:0] fa_addr;
    logic              fa_idx;
    logic [DATA_W-1:0] sum;
    logic              sum_zero;

    incskip_decode #(
        .INSTR_W (INSTR_W),
        .DATA_W  (DATA_W)
    ) u_decode (
        .word     (instr_word),
        .op       (dec_op),
        .to_file  (dec_to_file),
        .use_bank (dec_use_bank),
        .fsel     (dec_fsel)
    );

    incskip_addr #(
        .DATA_W    (DATA_W),
        .BANK_W    (BANK_W),
        .ACC_SPLIT (ACC_SPLIT)
    ) u_addr (
        .fsel     (dec_fsel),
        .use_bank (dec_use_bank),
        .bank_sel (bank_sel),
        .ext_en   (ext_set_en),
        .addr     (fa_addr),
        .idx      (fa_idx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ph   = qphase_e'(2'(s_q.ph + 2'd1));
        sum      = s_q.opnd + DATA_W'(1);
        sum_zero = (sum == '0);
        case (s_q.ph)
            PH_DEC: begin
                if (s_q.pend != '0) begin
                    s_d.pend = s_q.pend - FLUSH_ONE;
                    s_d.act  = 1'b0;
                end else begin
                    s_d.act     = instr_valid && (dec_op != OP_NONE);
                    s_d.op      = dec_op;
                    s_d.to_file = dec_to_file;
                    s_d.addr    = fa_addr;
                    s_d.idx     = fa_idx;
                    s_d.two     = next_two_word;
                end
                s_d.skip = 1'b0;
            end
            PH_RD: begin
                if (s_q.act && !s_q.idx) begin
                    s_d.opnd = rd_data;
                end
            end
            PH_EXE: begin
                s_d.res  = sum;
                s_d.skip = s_q.act && !s_q.idx &&
                           ((s_q.op == OP_SKZ) ? sum_zero : !sum_zero);
            end
            default: begin
                s_d.act  = 1'b0;
                s_d.skip = 1'b0;
                if (s_q.skip) begin
                    s_d.pend = s_q.two ? FLUSH_TWO : FLUSH_ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        qphase     = s_q.ph;
        file_addr  = s_q.addr;
        file_rd    = s_q.act && !s_q.idx && (s_q.ph == PH_RD);
        file_wr    = s_q.act && !s_q.idx && (s_q.ph == PH_WB) && s_q.to_file;
        w_wr       = s_q.act && !s_q.idx && (s_q.ph == PH_WB) && !s_q.to_file;
        file_wdata = s_q.res;
        w_wdata    = s_q.res;
        idx_mode   = s_q.act && s_q.idx;
        squash     = (s_q.ph == PH_DEC) && (s_q.pend != '0);
    end
endmodule

// File: rtl/incskip_unit_chk.sv
module incskip_unit_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        qphase,
    input logic              file_rd,
    input logic              file_wr,
    input logic              w_wr,
    input logic [DATA_W-1:0] file_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              idx_mode,
    input logic              squash
);
    a_r3_rd_phase: assert property (@(posedge clk) disable iff (!rst_n)
        file_rd |-> (qphase == 2'd1));

    a_r3_wr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (file_wr || w_wr) |-> (qphase == 2'd3));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (qphase == 2'd3) |=> (qphase == 2'd0));

    a_r4_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        !(file_wr && w_wr));

    a_r4_incr: assert property (@(posedge clk) disable iff (!rst_n)
        file_wr |-> (file_wdata == DATA_W'($past(rd_data, 2) + 1'b1)));

    a_r5_squash_q1: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (qphase == 2'd0));

    a_r6_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !file_rd);

    a_r7_idx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idx_mode |-> (!file_rd && !file_wr && !w_wr));
endmodule

bind incskip_unit incskip_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .qphase     (qphase),
    .file_rd    (file_rd),
    .file_wr    (file_wr),
    .w_wr       (w_wr),
    .file_wdata (file_wdata),
    .rd_data    (rd_data),
    .idx_mode   (idx_mode),
    .squash     (squash)
);

// File: tb/incskip_unit_bench.sv
module incskip_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic        instr_valid = 1'b0;
    logic        next_two_word = 1'b0;
    logic [3:0]  bank_sel = 4'h0;
    logic        ext_set_en = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic [1:0]  qphase;
    logic [11:0] file_addr;
    logic        file_rd, file_wr, w_wr, idx_mode, squash;
    logic [7:0]  file_wdata, w_wdata;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    incskip_unit u_incskip_unit (
        .clk (clk), .rst_n (rst_n), .instr_word (instr_word),
        .instr_valid (instr_valid), .next_two_word (next_two_word),
        .bank_sel (bank_sel), .ext_set_en (ext_set_en), .rd_data (rd_data),
        .qphase (qphase), .file_addr (file_addr), .file_rd (file_rd),
        .file_wr (file_wr), .file_wdata (file_wdata), .w_wr (w_wr),
        .w_wdata (w_wdata), .idx_mode (idx_mode), .squash (squash)
    );

    // word, two-word, bank, ext, rd_data, expected address, expected squash count
    localparam int NV = 10;
    localparam logic [43:0] VEC [NV] = '{
        {16'h3E20, 1'b0, 4'h0, 1'b0, 8'h05, 12'h020, 2'd0},
        {16'h3D7F, 1'b0, 4'h5, 1'b0, 8'hFF, 12'h57F, 2'd1},
        {16'h3F10, 1'b1, 4'hA, 1'b0, 8'hFF, 12'hA10, 2'd2},
        {16'h4A80, 1'b0, 4'h0, 1'b0, 8'h00, 12'hF80, 2'd1},
        {16'h485F, 1'b0, 4'h7, 1'b0, 8'hFF, 12'h05F, 2'd0},
        {16'h4BC3, 1'b1, 4'h3, 1'b0, 8'h41, 12'h3C3, 2'd2},
        {16'h3E60, 1'b0, 4'h0, 1'b1, 8'h7E, 12'hF60, 2'd0},
        {16'h3E5F, 1'b0, 4'h0, 1'b1, 8'hFF, 12'h000, 2'd0},
        {16'h3F10, 1'b0, 4'h2, 1'b1, 8'hFF, 12'h210, 2'd1},
        {16'h3A20, 1'b0, 4'h0, 1'b0, 8'hFF, 12'h000, 2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge with qphase == 0; returns at the next free phase 0.
    task automatic run_one(input logic [43:0] v);
        logic [15:0] w;
        logic [7:0]  f, res;
        logic        rec, skz, d, a, idxm, act;
        int          sq;
        w    = v[43:28];
        rec  = (w[15:10] == 6'b001111) || (w[15:10] == 6'b010010);
        skz  = (w[15:10] == 6'b001111);
        d    = w[9];
        a    = w[8];
        f    = w[7:0];
        idxm = rec && v[22] && !a && (f <= 8'h5F);
        act  = rec && !idxm;
        res  = v[21:14] + 8'd1;
        sq   = int'(v[1:0]);
        instr_word    = w;
        instr_valid   = 1'b1;
        next_two_word = v[27];
        bank_sel      = v[26:23];
        ext_set_en    = v[22];
        rd_data       = v[21:14];
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = 16'h0000;
        chk("R3 phase1", int'(qphase), 1);
        chk("R1 file_rd", int'(file_rd), int'(act));
        if (act) chk("R2 file_addr", int'(file_addr), int'(v[13:2]));
        chk("R7 idx_mode", int'(idx_mode), int'(idxm));
        @(negedge clk);
        @(negedge clk);
        chk("R3 phase3", int'(qphase), 3);
        chk("R4 file_wr", int'(file_wr), int'(act && d));
        chk("R4 w_wr", int'(w_wr), int'(act && !d));
        if (act && d)  chk("R4 file_wdata", int'(file_wdata), int'(res));
        if (act && !d) chk("R4 w_wdata", int'(w_wdata), int'(res));
        chk("R7 idx_mode q4", int'(idx_mode), int'(idxm));
        if (act) chk("R5 skip sense", sq != 0 ? 1 : 0, int'(skz ? (res == 8'h00) : (res != 8'h00)));
        @(negedge clk);
        for (int k = 0; k < sq; k++) begin
            chk("R5 squash high", int'(squash), 1);
            instr_word  = 16'h3E20;
            instr_valid = 1'b1;
            @(negedge clk);
            instr_valid = 1'b0;
            instr_word  = 16'h0000;
            chk("R6 no read in squash", int'(file_rd), 0);
            @(negedge clk);
            @(negedge clk);
            chk("R6 no write in squash", int'(file_wr || w_wr), 0);
            @(negedge clk);
        end
        chk("R5 squash low after", int'(squash), 0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R8 reset phase", int'(qphase), 0);
        chk("R8 reset strobes", int'(file_rd || file_wr || w_wr || idx_mode), 0);
        chk("R8 reset squash", int'(squash), 0);

        for (int i = 0; i < NV; i++) begin
            run_one(VEC[i]);
        end

        // r8_: reset while a two-cycle discard is pending
        instr_word    = 16'h3F10;
        instr_valid   = 1'b1;
        next_two_word = 1'b1;
        bank_sel      = 4'h1;
        ext_set_en    = 1'b0;
        rd_data       = 8'hFF;
        @(negedge clk);
        instr_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 squash before reset", int'(squash), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R8 squash cleared", int'(squash), 0);
        chk("R8 phase restart", int'(qphase), 0);
        next_two_word = 1'b0;
        run_one({16'h3E20, 1'b0, 4'h0, 1'b0, 8'h10, 12'h020, 2'd0});

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule